// File: doc/BRIEF.md
# System Control Register with Debug-Disable Write Gating

This block is a single 32-bit control word on a simple register bus. A write strobe with a full data word updates it, and the stored value is always visible on the read-data output. The word holds several controls and status fields. One field picks where the JTAG pins are routed. One swaps the two halves of code memory. One requests a cache flush. There is a boot-complete flag, a checksum start/busy bit with its result bit, a bit that disables the serial-wire debug port, and a two-bit operating-voltage range. Each field also drives an output pin of the same name for the logic around it.

The block issues one-cycle strobes to neighbouring logic. These strobes flush the data-bus read buffer and the instruction buffer whenever the memory-half swap changes. They flush the code cache when software requests it, and they start a checksum computation. An external checksum engine answers with a done pulse and a pass/fail flag. Two lock-status inputs, together with the boot-complete flag, decide whether software may change the debug-disable bit.

Top module: `plat_ctrl_reg`

## Requirements
- R1: After reset the read word and every output are 0.
- R2: Bit 1 is read/write and drives `tap_sel` (1 routes the JTAG pins to the boundary-scan TAP, 0 routes them to processor debug).
- R3: Bit 4 is read/write and drives `half_swap` (0 gives a straight mapping, 1 swaps the lower and upper halves of code memory).
- R4: A write whose bit 4 differs from the stored bit 4 raises `dbuf_flush` and `ibuf_flush` together for exactly the one cycle after the write edge. A write that leaves bit 4 unchanged raises neither.
- R5: A write with bit 6 set raises `cache_flush` for the one cycle after the write edge. Bit 6 always reads 0.
- R6: Bit 12 is a read/write boot-complete flag driving `boot_done`. A write to bit 14 (`swd_off`) takes effect only when `fw_locked` is 0, or when both `dbg_locked` and the stored bit 12 (the value held before that write) are 0. Otherwise bit 14 keeps its value.
- R7: When bit 13 reads 0, writing 1 to it sets it and raises `sum_start` for one cycle. While bit 13 is 1, writes to it (0 or 1) have no effect and no further start is issued. Bit 13 clears on the edge where `sum_done` is sampled high.
- R8: Bit 15 (0 pass, 1 fail) loads `sum_fail` only on the edge that completes a running checksum. Software writes and `sum_done` while idle leave it unchanged.
- R9: Bits 17:16 are a read/write voltage-range field driving `vrange`.
- R10: All other bits read 0 whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Full-word write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register value |
| fw_locked | input | 1 | Firmware lock word is programmed |
| dbg_locked | input | 1 | Debug lock word is programmed |
| sum_done | input | 1 | Checksum engine completion pulse |
| sum_fail | input | 1 | Checksum result, valid with `sum_done` |
| sum_start | output | 1 | One-cycle checksum start strobe |
| dbuf_flush | output | 1 | One-cycle data read-buffer flush |
| ibuf_flush | output | 1 | One-cycle instruction-buffer flush |
| cache_flush | output | 1 | One-cycle code-cache flush |
| tap_sel | output | 1 | Debug-port routing select |
| half_swap | output | 1 | Code-memory half swap |
| boot_done | output | 1 | Boot-complete flag |
| swd_off | output | 1 | Serial-wire debug disable |
| vrange | output | 2 | Operating voltage range |

## Verification
The assertions assume that `sum_done` arrives only as a response to a started computation. They also assume that the lock inputs change only between bus writes, so the permission seen at a write edge is the one that applies to it. The stimulus pulses `sum_done` only after a start has been observed, except in one deliberate case where it is pulsed while idle, and that case is checked against R8 at the ports. The lock inputs are changed only on cycles without a write. All four combinations of the two lock inputs and the boot flag are covered for writes to the debug-disable bit.

// File: rtl/plat_ctrl_pkg.sv
package plat_ctrl_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned VR_W      = 2;
  localparam int unsigned POS_TAP   = 1;
  localparam int unsigned POS_SWAP  = 4;
  localparam int unsigned POS_CFL   = 6;
  localparam int unsigned POS_BOOT  = 12;
  localparam int unsigned POS_SUM   = 13;
  localparam int unsigned POS_SWD   = 14;
  localparam int unsigned POS_RES   = 15;
  localparam int unsigned POS_VR    = 16;

  typedef struct packed {
    logic            tap;
    logic            swap;
    logic            boot;
    logic            swd;
    logic [VR_W-1:0] vr;
  } cfg_t;

  // Permission for a software write to the debug-disable bit.
  function automatic logic swd_write_ok(input logic fw_lk, input logic dbg_lk,
                                        input logic boot);
    return !fw_lk || (!dbg_lk && !boot);
  endfunction

  // Assemble the visible word; unlisted bits stay 0.
  function automatic logic [WORD_W-1:0] pack_word(input cfg_t c, input logic busy,
                                                  input logic res);
    logic [WORD_W-1:0] w;
    w = '0;
    w[POS_TAP]               = c.tap;
    w[POS_SWAP]              = c.swap;
    w[POS_BOOT]              = c.boot;
    w[POS_SUM]               = busy;
    w[POS_SWD]               = c.swd;
    w[POS_RES]               = res;
    w[POS_VR +: VR_W]        = c.vr;
    return w;
  endfunction
endpackage

// File: rtl/plat_ctrl_pulse.sv
module plat_ctrl_pulse #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] trig,
  output logic [N-1:0] pulse
);
  for (genvar i = 0; i < N; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse[i] <= 1'b0;
      else        pulse[i] <= trig[i];
    end
  end
endmodule

// File: rtl/plat_ctrl_sum.sv
module plat_ctrl_sum (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic done,
  input  logic fail,
  output logic busy,
  output logic start_pulse,
  output logic result
);
  logic accept;
  logic finish;

  assign accept = start_req && !busy;
  assign finish = busy && done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      start_pulse <= 1'b0;
      result      <= 1'b0;
    end else begin
      start_pulse <= accept;
      if (finish)      busy <= 1'b0;
      else if (accept) busy <= 1'b1;
      if (finish)      result <= fail;
    end
  end

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy); // R7
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> busy && !$past(busy)); // R7
  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done) |=> $stable(result)); // R8
endmodule

// File: rtl/plat_ctrl_reg.sv
module plat_ctrl_reg
  import plat_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  input  logic              fw_locked,
  input  logic              dbg_locked,
  input  logic              sum_done,
  input  logic              sum_fail,
  output logic              sum_start,
  output logic              dbuf_flush,
  output logic              ibuf_flush,
  output logic              cache_flush,
  output logic              tap_sel,
  output logic              half_swap,
  output logic              boot_done,
  output logic              swd_off,
  output logic [VR_W-1:0]   vrange
);
  localparam int unsigned N_PULSE = 2;

  cfg_t cfg_q;
  logic sum_busy;
  logic sum_res;

  // Named internal events
  logic swap_change;
  logic cflush_req;
  logic sum_req;
  logic swd_wr_ok;
  logic [N_PULSE-1:0] pulse_trig;
  logic [N_PULSE-1:0] pulse_out;

  assign swap_change = wr_en && (wr_data[POS_SWAP] != cfg_q.swap);
  assign cflush_req  = wr_en && wr_data[POS_CFL];
  assign sum_req     = wr_en && wr_data[POS_SUM];
  assign swd_wr_ok   = swd_write_ok(fw_locked, dbg_locked, cfg_q.boot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      cfg_q.tap  <= wr_data[POS_TAP];
      cfg_q.swap <= wr_data[POS_SWAP];
      cfg_q.boot <= wr_data[POS_BOOT];
      cfg_q.vr   <= wr_data[POS_VR +: VR_W];
      if (swd_wr_ok) cfg_q.swd <= wr_data[POS_SWD];
    end
  end

  assign pulse_trig = {cflush_req, swap_change};

  plat_ctrl_pulse #(.N(N_PULSE)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .trig  (pulse_trig),
    .pulse (pulse_out)
  );

  plat_ctrl_sum u_sum (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_req   (sum_req),
    .done        (sum_done),
    .fail        (sum_fail),
    .busy        (sum_busy),
    .start_pulse (sum_start),
    .result      (sum_res)
  );

  assign dbuf_flush  = pulse_out[0];
  assign ibuf_flush  = pulse_out[0];
  assign cache_flush = pulse_out[1];
  assign tap_sel     = cfg_q.tap;
  assign half_swap   = cfg_q.swap;
  assign boot_done   = cfg_q.boot;
  assign swd_off     = cfg_q.swd;
  assign vrange      = cfg_q.vr;
  assign rd_data     = pack_word(cfg_q, sum_busy, sum_res);

  AST_SWAP_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(half_swap) |-> dbuf_flush && ibuf_flush); // R4
  AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !dbuf_flush && !cache_flush); // R4
  AST_SWD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    fw_locked && (dbg_locked || boot_done) |=> $stable(swd_off)); // R6
  AST_CFL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cache_flush |-> !rd_data[POS_CFL]); // R5
endmodule

// File: tb/plat_ctrl_reg_tb_top.sv
module plat_ctrl_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        fw_locked = 1'b0, dbg_locked = 1'b0, sum_done = 1'b0, sum_fail = 1'b0;
  logic        sum_start, dbuf_flush, ibuf_flush, cache_flush;
  logic        tap_sel, half_swap, boot_done, swd_off;
  logic [1:0]  vrange;

  int checks = 0;
  int errors = 0;

  // Reference model state
  bit m_tap, m_swap, m_boot, m_busy, m_swd, m_res, m_dfl, m_cfl, m_start;
  bit [1:0] m_vr;

  always #5 clk = ~clk;

  plat_ctrl_reg dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .fw_locked(fw_locked), .dbg_locked(dbg_locked), .sum_done(sum_done),
    .sum_fail(sum_fail), .sum_start(sum_start), .dbuf_flush(dbuf_flush),
    .ibuf_flush(ibuf_flush), .cache_flush(cache_flush), .tap_sel(tap_sel),
    .half_swap(half_swap), .boot_done(boot_done), .swd_off(swd_off), .vrange(vrange)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_word();
    logic [31:0] w = '0;
    w[1] = m_tap;  w[4] = m_swap; w[12] = m_boot; w[13] = m_busy;
    w[14] = m_swd; w[15] = m_res; w[17:16] = m_vr;
    return w;
  endfunction

  task automatic compare_all();
    chk("R2 tap",        {31'b0, tap_sel},   {31'b0, m_tap});
    chk("R3 swap",       {31'b0, half_swap}, {31'b0, m_swap});
    chk("R4 dbuf",       {31'b0, dbuf_flush}, {31'b0, m_dfl});
    chk("R4 ibuf",       {31'b0, ibuf_flush}, {31'b0, m_dfl});
    chk("R5 cache",      {31'b0, cache_flush}, {31'b0, m_cfl});
    chk("R6 swd",        {31'b0, swd_off},   {31'b0, m_swd});
    chk("R7 start",      {31'b0, sum_start}, {31'b0, m_start});
    chk("R9 vrange",     {30'b0, vrange},    {30'b0, m_vr});
    chk("R10 word",      rd_data,            model_word());
  endtask

  // One bus cycle: compare at the falling edge, drive, then advance the model at the rising edge.
  task automatic step(input bit wr, input logic [31:0] wd, input bit done = 0, input bit fail = 0);
    bit ok;
    @(negedge clk);
    compare_all();
    wr_en = wr; wr_data = wd; sum_done = done; sum_fail = fail;
    @(posedge clk);
    ok      = !fw_locked || (!dbg_locked && !m_boot);
    m_dfl   = wr && (wd[4] != m_swap);
    m_cfl   = wr && wd[6];
    m_start = wr && wd[13] && !m_busy;
    if (m_busy && done) begin m_res = fail; m_busy = 0; end
    else if (m_start) m_busy = 1;
    if (wr) begin
      if (ok) m_swd = wd[14];
      m_tap = wd[1]; m_swap = wd[4]; m_boot = wd[12]; m_vr = wd[17:16];
    end
  endtask

  task automatic set_locks(input bit fw, input bit dbg);
    @(negedge clk);
    compare_all();
    fw_locked = fw; dbg_locked = dbg; wr_en = 0; sum_done = 0;
    @(posedge clk);
    m_dfl = 0; m_cfl = 0; m_start = 0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset word", rd_data, 32'h0);
    chk("R1 reset strobes", {28'b0, sum_start, dbuf_flush, ibuf_flush, cache_flush}, 32'h0);
    // R2, R9, R10: plain fields and unused bits
    step(1, 32'h0000_0002);
    step(1, 32'h0001_0000);
    step(1, 32'hFFFC_0F2D & ~32'h0000_2000);
    step(1, 32'h0003_0000);
    step(0, 32'h0);
    // R3/R4: swap toggles and a no-change write
    step(1, 32'h0000_0010);
    step(1, 32'h0000_0010);
    step(1, 32'h0000_0000);
    step(0, 32'h0);
    // R5: cache flush request, back-to-back
    step(1, 32'h0000_0040);
    step(1, 32'h0000_0040);
    step(0, 32'h0);
    // R7/R8: start, ignored writes while busy, done with fail
    step(1, 32'h0000_2000);
    step(1, 32'h0000_8000);
    step(1, 32'h0000_2000);
    step(0, 32'h0, 1, 1);
    step(0, 32'h0);
    step(1, 32'h0000_0000);
    step(0, 32'h0, 1, 0);       // done while idle: result must stay 1 (R8)
    step(1, 32'h0000_2000);
    step(0, 32'h0);
    step(0, 32'h0, 1, 0);
    step(0, 32'h0);
    // R6: debug-disable permission in each lock/boot combination
    step(1, 32'h0000_4000);     // unlocked
    set_locks(1, 0);
    step(1, 32'h0000_0000);     // fw locked, dbg open, boot 0: allowed
    step(1, 32'h0000_5000);     // allowed, and sets boot
    step(1, 32'h0000_1000);     // boot 1: refused
    set_locks(1, 1);
    step(1, 32'h0000_0000);     // dbg locked: refused, boot cleared
    step(1, 32'h0000_0000);
    set_locks(0, 1);
    step(1, 32'h0000_0000);     // fw open: allowed
    step(0, 32'h0);
    step(0, 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule